// File: doc/BRIEF.md
# Serial Interrupt Vector Generator

This block sits beside a serial receiver/transmitter pair and turns their status flags into a single interrupt request and an 8-bit interrupt vector. The upper five vector bits are a base written by software. The next two bits are a source code that hardware fills in with the highest-priority enabled source. The least significant bit always reads zero. As a result, each source class lands on its own even vector slot above the software base.

The receiver and transmitter status flags arrive as levels held by their owners. The two end-of-block events from the DMA engine arrive as single-cycle pulses, and this block keeps them as sticky flags. Software clears those flags by writing zero. A small register port gives software access to the vector register and a mask register. The mask register holds one enable bit per source group, the two end-of-block flags, and a select bit. The select bit decides whether "transmitter empty" means the holding buffer or the shift register.

Top module: `sci_irq_vector`

## Requirements
- R1: Reading with `reg_sel`=0 returns {base[4:0], code[1:0], 0}. Bits 7:3 hold the last value written there, and write data in bits 2:0 has no effect.
- R2: The source codes are: 00 for a receiver error, 01 for break or address match, 10 for receive data or receive end-of-block, and 11 for transmitter empty or transmit end-of-block. When several enabled groups are pending, the lowest code is reported.
- R3: `irq` is high exactly when at least one enabled group is pending. The code field is 00 when `irq` is low.
- R4: Mask bit 4 enables the error group (overrun, parity or framing). Mask bit 3 enables address match. Mask bit 2 enables break. Break and address match share code 01.
- R5: Mask bit 1 enables receive data and the receive end-of-block flag. Mask bit 0 enables transmitter empty and the transmit end-of-block flag.
- R6: Mask bit 7 = 1 takes `txbuf_empty` as the transmitter-empty condition. Mask bit 7 = 0 takes `txshift_empty`.
- R7: Mask bit 6 (receive end-of-block) and mask bit 5 (transmit end-of-block) are set by a pulse on `rx_eob_pulse` or `tx_eob_pulse` and stay set. Software clears one by writing 0 to its bit. Writing 1 to either bit has no effect.
- R8: If an end-of-block pulse arrives in the same cycle as a software write of 0 to its flag, the flag ends up set.
- R9: After synchronous reset, the mask register reads 0x00 and `irq` is low while no flags are pending.
- R10: Writes to the mask register (`reg_sel`=1) store bits 7 and 4:0 directly and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the vector register, 1 selects the mask register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ovr_flag | input | 1 | Receiver overrun pending |
| par_flag | input | 1 | Receiver parity error pending |
| frm_flag | input | 1 | Receiver framing error pending |
| brk_flag | input | 1 | Break detected |
| adr_flag | input | 1 | Address match pending |
| rxd_flag | input | 1 | Received data pending |
| txbuf_empty | input | 1 | Transmit holding buffer empty |
| txshift_empty | input | 1 | Transmit shift register empty |
| rx_eob_pulse | input | 1 | Receive DMA end of block, one cycle |
| tx_eob_pulse | input | 1 | Transmit DMA end of block, one cycle |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Current interrupt vector |

## Verification
Assertions check the following on every cycle:
- an end-of-block pulse always leaves its flag set one cycle later;
- a set flag survives every cycle that does not write 0 to it;
- the vector base changes only on a vector write;
- a pending enabled error always forces code 00;
- a request with code 11 always has the transmit enable set.

Only the bench scenarios show the complete priority order, which needs an exhaustive sweep over every enable combination against every flag pattern. The same holds for the buffer-versus-shift selection, the collision of a pulse with a software clear, and the read-back layout of both registers.

// File: rtl/sci_irq_vector.sv
module sci_irq_vector #(
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BASE_W+2:0] reg_wdata,
  output logic [BASE_W+2:0] reg_rdata,
  input  logic              ovr_flag,
  input  logic              par_flag,
  input  logic              frm_flag,
  input  logic              brk_flag,
  input  logic              adr_flag,
  input  logic              rxd_flag,
  input  logic              txbuf_empty,
  input  logic              txshift_empty,
  input  logic              rx_eob_pulse,
  input  logic              tx_eob_pulse,
  output logic              irq,
  output logic [BASE_W+2:0] irq_vec
);
  localparam int VEC_W  = BASE_W + 3;
  localparam int MASK_W = 8;

  logic [BASE_W-1:0] base_q;
  logic tx_sel_q, rxeob_q, txeob_q, err_en_q, adr_en_q, brk_en_q, rxd_en_q, txe_en_q;
  logic [3:0] grp;
  logic [1:0] code;
  logic [MASK_W-1:0] mask_word;

  wire wr_vec = reg_wr & ~reg_sel;
  wire wr_msk = reg_wr & reg_sel;

  // vector base has no reset value
  always_ff @(posedge clk)
    if (wr_vec) base_q <= reg_wdata[VEC_W-1:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sel_q <= 1'b0;
      err_en_q <= 1'b0;
      adr_en_q <= 1'b0;
      brk_en_q <= 1'b0;
      rxd_en_q <= 1'b0;
      txe_en_q <= 1'b0;
    end else if (wr_msk) begin
      tx_sel_q <= reg_wdata[7];
      err_en_q <= reg_wdata[4];
      adr_en_q <= reg_wdata[3];
      brk_en_q <= reg_wdata[2];
      rxd_en_q <= reg_wdata[1];
      txe_en_q <= reg_wdata[0];
    end
  end

  // hardware set wins over a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rxeob_q <= 1'b0;
      txeob_q <= 1'b0;
    end else begin
      if (rx_eob_pulse)                  rxeob_q <= 1'b1;
      else if (wr_msk && !reg_wdata[6])  rxeob_q <= 1'b0;
      if (tx_eob_pulse)                  txeob_q <= 1'b1;
      else if (wr_msk && !reg_wdata[5])  txeob_q <= 1'b0;
    end
  end

  wire tx_empty = tx_sel_q ? txbuf_empty : txshift_empty;

  assign grp[0] = err_en_q & (ovr_flag | par_flag | frm_flag);
  assign grp[1] = (adr_en_q & adr_flag) | (brk_en_q & brk_flag);
  assign grp[2] = rxd_en_q & (rxd_flag | rxeob_q);
  assign grp[3] = txe_en_q & (tx_empty | txeob_q);

  always_comb begin
    if      (grp[0]) code = 2'd0;
    else if (grp[1]) code = 2'd1;
    else if (grp[2]) code = 2'd2;
    else if (grp[3]) code = 2'd3;
    else             code = 2'd0;
  end

  assign irq       = |grp;
  assign irq_vec   = {base_q, code, 1'b0};
  assign mask_word = {tx_sel_q, rxeob_q, txeob_q, err_en_q, adr_en_q, brk_en_q, rxd_en_q, txe_en_q};
  assign reg_rdata = reg_sel ? VEC_W'(mask_word) : irq_vec;

  a_r7_rx_eob_sets: assert property (@(posedge clk) disable iff (rst)
    rx_eob_pulse |=> mask_word[6]);
  a_r7_tx_eob_sets: assert property (@(posedge clk) disable iff (rst)
    tx_eob_pulse |=> mask_word[5]);
  a_r7_rx_eob_sticky: assert property (@(posedge clk) disable iff (rst)
    (mask_word[6] && !(wr_msk && !reg_wdata[6])) |=> mask_word[6]);
  a_r1_base_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_vec |=> $stable(irq_vec[VEC_W-1:3]));
  a_r2_error_first: assert property (@(posedge clk) disable iff (rst)
    (mask_word[4] && (ovr_flag || par_flag || frm_flag)) |-> (irq && irq_vec[2:1] == 2'd0));
  a_r5_tx_code_enabled: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_vec[2:1] == 2'd3) |-> mask_word[0]);
endmodule

// File: tb/tb_sci_irq_vector.sv
module tb_sci_irq_vector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, irq_vec;
  logic ovr_flag = 0, par_flag = 0, frm_flag = 0, brk_flag = 0, adr_flag = 0, rxd_flag = 0;
  logic txbuf_empty = 0, txshift_empty = 0, rx_eob_pulse = 0, tx_eob_pulse = 0;
  logic irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sci_irq_vector dut (.*);

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d,
                    input logic rxp = 1'b0, input logic txp = 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    rx_eob_pulse = rxp; tx_eob_pulse = txp;
    @(negedge clk);
    reg_wr = 1'b0; rx_eob_pulse = 1'b0; tx_eob_pulse = 1'b0;
  endtask

  task automatic pulse(input logic rxp, input logic txp);
    @(negedge clk);
    rx_eob_pulse = rxp; tx_eob_pulse = txp;
    @(negedge clk);
    rx_eob_pulse = 1'b0; tx_eob_pulse = 1'b0;
  endtask

  // returns {irq, code}; f: 0 ovr 1 par 2 frm 3 brk 4 adr 5 rxd 6 txbuf 7 txshift
  function automatic logic [2:0] model(input logic [7:0] m, input logic [7:0] f);
    logic g0, g1, g2, g3, te;
    te = m[7] ? f[6] : f[7];
    g0 = m[4] & (|f[2:0]);
    g1 = (m[3] & f[4]) | (m[2] & f[3]);
    g2 = m[1] & (f[5] | m[6]);
    g3 = m[0] & (te | m[5]);
    if (g0) return 3'b100;
    if (g1) return 3'b101;
    if (g2) return 3'b110;
    if (g3) return 3'b111;
    return 3'b000;
  endfunction

  task automatic set_flags(input logic [7:0] f);
    {txshift_empty, txbuf_empty, rxd_flag, adr_flag, brk_flag, frm_flag, par_flag, ovr_flag} = f;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reg_sel = 1'b1;
    #1;
    chk("R9 mask after reset", {1'b0, reg_rdata}, 9'h000);
    chk("R9 irq after reset", {8'h00, irq}, 9'h000);

    wr(1'b0, 8'hA7);
    reg_sel = 1'b0; #1;
    chk("R1 base readback, low bits ignored", {1'b0, reg_rdata}, 9'h0A0);
    chk("R1 vector port", {1'b0, irq_vec}, 9'h0A0);

    wr(1'b1, 8'h9F);
    reg_sel = 1'b1; #1;
    chk("R10 mask readback", {1'b0, reg_rdata}, 9'h09F);

    // exhaustive sweep over enables x level flags
    for (int mi = 0; mi < 64; mi++) begin
      logic [7:0] m;
      m = {mi[5], 2'b00, mi[4:0]};
      wr(1'b1, m);
      for (int fi = 0; fi < 256; fi++) begin
        logic [2:0] e;
        @(negedge clk);
        set_flags(fi[7:0]);
        #1;
        e = model(m, fi[7:0]);
        chk("R2 R3 R4 R5 R6 irq and code", {irq, irq_vec}, {e[2], 5'b10100, e[1:0], 1'b0});
      end
    end
    @(negedge clk);
    set_flags(8'h00);

    // end-of-block flags
    wr(1'b1, 8'h00);
    pulse(1'b1, 1'b0);
    reg_sel = 1'b1; #1;
    chk("R7 rx eob set by pulse", {1'b0, reg_rdata}, 9'h040);
    chk("R7 rx eob masked off, no irq", {8'h00, irq}, 9'h000);
    pulse(1'b0, 1'b1);
    #1;
    chk("R7 tx eob set, rx held", {1'b0, reg_rdata}, 9'h060);
    wr(1'b1, 8'h62);
    reg_sel = 1'b0; #1;
    chk("R5 rx eob gives code 10", {irq, irq_vec}, {1'b1, 8'hA4});
    wr(1'b1, 8'h61);
    #1;
    chk("R5 tx eob gives code 11", {irq, irq_vec}, {1'b1, 8'hA6});
    wr(1'b1, 8'h20, 1'b1, 1'b0);
    reg_sel = 1'b1; #1;
    chk("R8 rx set beats clear", {1'b0, reg_rdata}, 9'h060);
    wr(1'b1, 8'h40);
    #1;
    chk("R7 tx cleared by writing 0", {1'b0, reg_rdata}, 9'h040);
    wr(1'b1, 8'h00);
    #1;
    chk("R7 rx cleared by writing 0", {1'b0, reg_rdata}, 9'h000);
    wr(1'b1, 8'h60);
    #1;
    chk("R7 writing 1 does not set", {1'b0, reg_rdata}, 9'h000);
    wr(1'b1, 8'h00, 1'b0, 1'b1);
    #1;
    chk("R8 tx set beats clear", {1'b0, reg_rdata}, 9'h020);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule